// File: doc/BRIEF.md
# Dual-Port Address Contention Arbiter

This block sits in front of a memory array that two independent ports, left and right, share. Each port presents an enable, an address and a write strobe every clock. When both ports are enabled on the same word, the block lets one of them through and raises an active-low busy flag toward the other. It also removes the write permission of the port that lost. Reads are never gated: the array delivers the stored word to both ports.

The port that reached the shared word first keeps it for as long as the clash lasts. The decision is kept in a registered state machine. To find which port arrived first, the block registers each port's request and compares it with the current one. The port whose enable or address changed in the current cycle is the later one. If both changed, or neither did, the left port wins.

A mode input picks master or slave operation. In master mode the block arbitrates and drives its busy outputs. In slave mode the busy outputs stay inactive and the state machine stays idle. Busy then comes from an external master through two active-low inputs, and only suppresses the matching port's write. All outputs are combinational from the current requests and the registered state, so a clash gates a write in the same cycle it appears.

State machine: `ARB_FREE` (no clash), `ARB_LEFT_OWNS` (left holds the word, right busy), `ARB_RIGHT_OWNS` (right holds it, left busy).

Transitions:
- *claim_left*: `ARB_FREE` to `ARB_LEFT_OWNS` on a clash where the right port moved alone, both moved, or neither moved.
- *claim_right*: `ARB_FREE` to `ARB_RIGHT_OWNS` on a clash where only the left port moved.
- *release*: either owner state back to `ARB_FREE` when the clash ends or slave mode is selected.
- *hold*: either owner state stays in place while the clash continues in master mode.

Top module: `dpca_top`

## Requirements
- R1: After reset, with both ports idle, both busy outputs are high (inactive), both write grants are low, and the arbiter is free.
- R2: A clash exists only when both enables are high and the two addresses are equal. An enabled pair on different words, or a matching address with one port disabled, raises no busy.
- R3: On a clash, the port that was already holding its enable and address in the previous cycle wins. Busy (low) is driven only toward the port that changed.
- R4: When both ports change into a clash in the same cycle, the left port wins and right busy goes low.
- R5: Busy goes low in the same cycle the clash forms. The clash can form because an address moves onto the other port's word, or because the second enable rises on a word that already matches.
- R6: Busy returns high in the same cycle the addresses differ or either enable drops.
- R7: While a clash lasts in master mode, the winner does not change, even when neither port moves.
- R8: A write grant is high only when its port is enabled with its write strobe high and it is not busy. The busy port's write grant is low, and the winner's grant follows its strobe.
- R9: With the mode input low (slave), both busy outputs stay high and no arbitration takes place.
- R10: In slave mode, an active-low busy input blocks the write grant of its own port. In master mode the busy inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| master_mode | input | 1 | 1 = arbitrate and drive busy, 0 = take busy from the inputs |
| l_en | input | 1 | left port enable |
| l_addr | input | AW | left port word address |
| l_wr | input | 1 | left port write strobe |
| r_en | input | 1 | right port enable |
| r_addr | input | AW | right port word address |
| r_wr | input | 1 | right port write strobe |
| l_busy_in_n | input | 1 | external busy toward left, active low, used in slave mode |
| r_busy_in_n | input | 1 | external busy toward right, active low, used in slave mode |
| l_busy_n | output | 1 | busy toward left, active low |
| r_busy_n | output | 1 | busy toward right, active low |
| l_wr_go | output | 1 | write enable from left port to the array |
| r_wr_go | output | 1 | write enable from right port to the array |

## Verification
The bench builds the block with its default address width of 13 bits. The comparison logic is therefore as wide as an 8K-word array, while the directed addresses stay small and easy to read. With this width, tests can move one port's address across the other's word, away from it and back. These moves exercise arrival by address, arrival by enable, the hold of a winner while neither port moves, and release on mismatch or on a dropped enable. Slave mode is reached by driving the mode input low, and the busy inputs are then driven in both polarities.

// File: rtl/dpca_pkg.sv
package dpca_pkg;

    typedef enum logic [1:0] {
        ARB_FREE       = 2'd0,
        ARB_LEFT_OWNS  = 2'd1,
        ARB_RIGHT_OWNS = 2'd2
    } arb_state_e;

    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned PORT_L    = 0;
    localparam int unsigned PORT_R    = 1;

endpackage

// File: rtl/dpca_arrival.sv
// Detects a clash between the two ports and decides which side arrived later
// by comparing each port's request with the one registered on the last edge.
module dpca_arrival #(
    parameter int unsigned AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_en,
    input  logic [AW-1:0] l_addr,
    input  logic          r_en,
    input  logic [AW-1:0] r_addr,
    output logic          clash,
    output logic          left_later
);

    logic          l_en_q, r_en_q;
    logic [AW-1:0] l_addr_q, r_addr_q;
    logic          l_moved, r_moved;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_en_q   <= 1'b0;
            r_en_q   <= 1'b0;
            l_addr_q <= '0;
            r_addr_q <= '0;
        end else begin
            l_en_q   <= l_en;
            r_en_q   <= r_en;
            l_addr_q <= l_addr;
            r_addr_q <= r_addr;
        end
    end

    always_comb begin
        clash      = l_en && r_en && (l_addr == r_addr);
        l_moved    = (l_en != l_en_q) || (l_addr != l_addr_q);
        r_moved    = (r_en != r_en_q) || (r_addr != r_addr_q);
        // Only a lone move by the left port hands the word to the right port.
        left_later = l_moved && !r_moved;
    end

endmodule

// File: rtl/dpca_fsm.sv
// Ownership state machine: the winner is registered and held while the clash lasts.
module dpca_fsm
    import dpca_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic master_mode,
    input  logic clash,
    input  logic left_later,
    output logic l_busy_arb,
    output logic r_busy_arb
);

    arb_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_FREE: begin
                if (master_mode && clash) begin
                    state_d = left_later ? ARB_RIGHT_OWNS : ARB_LEFT_OWNS;
                end
            end
            ARB_LEFT_OWNS, ARB_RIGHT_OWNS: begin
                if (!master_mode || !clash) begin
                    state_d = ARB_FREE;
                end
            end
            default: state_d = ARB_FREE;
        endcase
    end

    // Outputs follow the decision of this cycle so a clash gates at once.
    always_comb begin
        l_busy_arb = (state_d == ARB_RIGHT_OWNS);
        r_busy_arb = (state_d == ARB_LEFT_OWNS);
    end

endmodule

// File: rtl/dpca_wr_gate.sv
// Per-port write permission: the busy source depends on the mode.
module dpca_wr_gate (
    input  logic master_mode,
    input  logic en,
    input  logic wr,
    input  logic arb_busy,
    input  logic ext_busy_n,
    output logic wr_go
);

    logic blocked;

    always_comb begin
        blocked = master_mode ? arb_busy : !ext_busy_n;
        wr_go   = en && wr && !blocked;
    end

endmodule

// File: rtl/dpca_top.sv
module dpca_top
    import dpca_pkg::*;
#(
    parameter int unsigned AW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          master_mode,
    input  logic          l_en,
    input  logic [AW-1:0] l_addr,
    input  logic          l_wr,
    input  logic          r_en,
    input  logic [AW-1:0] r_addr,
    input  logic          r_wr,
    input  logic          l_busy_in_n,
    input  logic          r_busy_in_n,
    output logic          l_busy_n,
    output logic          r_busy_n,
    output logic          l_wr_go,
    output logic          r_wr_go
);

    logic clash, left_later;
    logic l_busy_arb, r_busy_arb;
    logic [NUM_PORTS-1:0] en_v, wr_v, arb_busy_v, ext_busy_n_v, wr_go_v;

    dpca_arrival #(.AW(AW)) u_arrival (
        .clk        (clk),
        .rst_n      (rst_n),
        .l_en       (l_en),
        .l_addr     (l_addr),
        .r_en       (r_en),
        .r_addr     (r_addr),
        .clash      (clash),
        .left_later (left_later)
    );

    dpca_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .master_mode (master_mode),
        .clash       (clash),
        .left_later  (left_later),
        .l_busy_arb  (l_busy_arb),
        .r_busy_arb  (r_busy_arb)
    );

    always_comb begin
        en_v[PORT_L]         = l_en;
        en_v[PORT_R]         = r_en;
        wr_v[PORT_L]         = l_wr;
        wr_v[PORT_R]         = r_wr;
        arb_busy_v[PORT_L]   = l_busy_arb;
        arb_busy_v[PORT_R]   = r_busy_arb;
        ext_busy_n_v[PORT_L] = l_busy_in_n;
        ext_busy_n_v[PORT_R] = r_busy_in_n;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        dpca_wr_gate u_gate (
            .master_mode (master_mode),
            .en          (en_v[p]),
            .wr          (wr_v[p]),
            .arb_busy    (arb_busy_v[p]),
            .ext_busy_n  (ext_busy_n_v[p]),
            .wr_go       (wr_go_v[p])
        );
    end

    always_comb begin
        l_busy_n = !(master_mode && l_busy_arb);
        r_busy_n = !(master_mode && r_busy_arb);
        l_wr_go  = wr_go_v[PORT_L];
        r_wr_go  = wr_go_v[PORT_R];
    end

endmodule

// File: rtl/dpca_checker.sv
module dpca_checker #(
    parameter int unsigned AW = 13
) (
    input logic          clk,
    input logic          rst_n,
    input logic          master_mode,
    input logic          l_en,
    input logic [AW-1:0] l_addr,
    input logic          r_en,
    input logic [AW-1:0] r_addr,
    input logic          l_busy_in_n,
    input logic          r_busy_in_n,
    input logic          l_busy_n,
    input logic          r_busy_n,
    input logic          l_wr_go,
    input logic          r_wr_go
);

    logic clash_now;
    logic run_q;

    assign clash_now = l_en && r_en && (l_addr == r_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    p_one_side_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!l_busy_n && !r_busy_n));

    p_busy_needs_clash_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n || !r_busy_n) |-> (clash_now && master_mode));

    p_clash_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && clash_now) |-> (!l_busy_n || !r_busy_n));

    p_hold_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && master_mode && clash_now && !$past(l_busy_n)) |-> !l_busy_n);

    p_hold_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && master_mode && clash_now && !$past(r_busy_n)) |-> !r_busy_n);

    p_gate_left_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !l_busy_n |-> !l_wr_go);

    p_gate_right_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !r_busy_n |-> !r_wr_go);

    p_slave_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !master_mode |-> (l_busy_n && r_busy_n));

    p_slave_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!master_mode && (!l_busy_in_n || !r_busy_in_n))
            |-> ((l_busy_in_n || !l_wr_go) && (r_busy_in_n || !r_wr_go)));

endmodule

bind dpca_top dpca_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .l_en        (l_en),
    .l_addr      (l_addr),
    .r_en        (r_en),
    .r_addr      (r_addr),
    .l_busy_in_n (l_busy_in_n),
    .r_busy_in_n (r_busy_in_n),
    .l_busy_n    (l_busy_n),
    .r_busy_n    (r_busy_n),
    .l_wr_go     (l_wr_go),
    .r_wr_go     (r_wr_go)
);

// File: tb/sim_dpca_top.sv
`timescale 1ns/1ps
module sim_dpca_top;

    localparam int unsigned AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          master_mode = 1'b1;
    logic          l_en = 1'b0, r_en = 1'b0, l_wr = 1'b0, r_wr = 1'b0;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic          l_busy_in_n = 1'b1, r_busy_in_n = 1'b1;
    logic          l_busy_n, r_busy_n, l_wr_go, r_wr_go;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = !clk;

    dpca_top #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
        .l_en(l_en), .l_addr(l_addr), .l_wr(l_wr),
        .r_en(r_en), .r_addr(r_addr), .r_wr(r_wr),
        .l_busy_in_n(l_busy_in_n), .r_busy_in_n(r_busy_in_n),
        .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
        .l_wr_go(l_wr_go), .r_wr_go(r_wr_go)
    );

    // Expected vector order: {l_busy_n, r_busy_n, l_wr_go, r_wr_go}
    task automatic expect_out(input string req, input logic [3:0] exp);
        logic [3:0] act;
        act = {l_busy_n, r_busy_n, l_wr_go, r_wr_go};
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input logic le, input logic [AW-1:0] la, input logic lw,
                        input logic re, input logic [AW-1:0] ra, input logic rw);
        @(negedge clk);
        l_en = le; l_addr = la; l_wr = lw;
        r_en = re; r_addr = ra; r_wr = rw;
        #1;
    endtask

    task automatic go_idle();
        step(1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
        step(1'b0, '0, 1'b0, 1'b0, '0, 1'b0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        expect_out("R1 idle after reset", 4'b1100);
    endtask

    task automatic t_right_late();
        step(1'b1, 13'd5, 1'b0, 1'b1, 13'd9, 1'b0);
        expect_out("R2 different words", 4'b1100);
        step(1'b1, 13'd5, 1'b0, 1'b0, 13'd5, 1'b0);
        expect_out("R2 same word one port off", 4'b1100);
        step(1'b1, 13'd5, 1'b0, 1'b1, 13'd5, 1'b0);
        expect_out("R5 second enable on matching word", 4'b1000);
        step(1'b1, 13'd5, 1'b0, 1'b1, 13'd6, 1'b0);
        expect_out("R6 release on mismatch", 4'b1100);
        step(1'b1, 13'd5, 1'b0, 1'b1, 13'd5, 1'b0);
        expect_out("R3 right moved onto left word", 4'b1000);
        step(1'b0, 13'd5, 1'b0, 1'b1, 13'd5, 1'b0);
        expect_out("R6 release on enable drop", 4'b1100);
        go_idle();
    endtask

    task automatic t_left_late();
        step(1'b1, 13'd4, 1'b0, 1'b1, 13'd3, 1'b0);
        expect_out("R2 no clash before move", 4'b1100);
        step(1'b1, 13'd3, 1'b0, 1'b1, 13'd3, 1'b0);
        expect_out("R3 left moved onto right word", 4'b0100);
        for (int i = 0; i < 3; i++) begin
            step(1'b1, 13'd3, 1'b0, 1'b1, 13'd3, 1'b0);
            expect_out("R7 winner held with no movement", 4'b0100);
        end
        step(1'b1, 13'd3, 1'b1, 1'b1, 13'd3, 1'b1);
        expect_out("R8 busy left write gated, right write passes", 4'b0101);
        go_idle();
    endtask

    task automatic t_simultaneous();
        step(1'b1, 13'd12, 1'b1, 1'b1, 13'd12, 1'b1);
        expect_out("R4 both enable together left wins", 4'b1010);
        go_idle();
        step(1'b1, 13'd1, 1'b0, 1'b1, 13'd2, 1'b0);
        expect_out("R2 separate words", 4'b1100);
        step(1'b1, 13'd7, 1'b1, 1'b1, 13'd7, 1'b1);
        expect_out("R4 both move together left wins", 4'b1010);
        step(1'b1, 13'd7, 1'b1, 1'b1, 13'd7, 1'b0);
        expect_out("R8 winner write follows strobe", 4'b1010);
        go_idle();
    endtask

    task automatic t_slave();
        master_mode = 1'b0;
        l_busy_in_n = 1'b0;
        r_busy_in_n = 1'b1;
        step(1'b1, 13'd7, 1'b1, 1'b1, 13'd7, 1'b1);
        expect_out("R9 slave no busy outputs", 4'b1101);
        l_busy_in_n = 1'b1;
        r_busy_in_n = 1'b0;
        step(1'b1, 13'd7, 1'b1, 1'b1, 13'd7, 1'b1);
        expect_out("R10 slave right write blocked", 4'b1110);
        master_mode = 1'b1;
        l_busy_in_n = 1'b0;
        r_busy_in_n = 1'b0;
        step(1'b1, 13'd7, 1'b1, 1'b1, 13'd8, 1'b1);
        expect_out("R10 busy inputs ignored in master", 4'b1111);
        l_busy_in_n = 1'b1;
        r_busy_in_n = 1'b1;
        go_idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_right_late();
        t_left_late();
        t_simultaneous();
        t_slave();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule